// File: doc/BRIEF.md
# Working Register Bank with Pointer Pairs

This block is the general-purpose register storage of a small 8-bit CPU datapath. It holds sixteen 8-bit registers that instructions name with the numbers 16 to 31. Two combinational read ports feed an ALU. One write port takes its result back at the next clock edge, so a read, the operation and the write-back fit in one cycle.

The six highest registers also serve as three 16-bit address pointers. A separate pointer path reads a selected pointer as one 16-bit value. In the same cycle it can load a new 16-bit value into it, or step it by one. A post-increment presents the old value as the access address and stores value+1. A pre-decrement presents value-1 and stores that same value. A pointer update that lands on a register also targeted by the 8-bit write port wins over that write. Reads always return the contents held before the current edge.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all sixteen registers to 0x00.
- R2: Register addresses are 5 bits wide. Bit 4 is ignored and bits 3:0 pick entry k, which is register number 16+k. So address 5'h03 and address 5'h13 reach the same register.
- R3: rd_a_data and rd_b_data show the current contents of the registers at rd_a_addr and rd_b_addr, independently and in the same cycle. With wr_en high, wr_data is stored into the register at wr_addr at the rising edge, and no other register changes.
- R4: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle on.
- R5: ptr_sel 2'b00 selects pointer X = {reg27, reg26}, 2'b01 selects Y = {reg29, reg28} and 2'b10 selects Z = {reg31, reg30}. The odd register is the high byte. ptr_rd_data shows the selected pointer, and shows 0x0000 when ptr_sel is 2'b11.
- R6: ptr_op 2'b01 (load) writes ptr_ld_data into the selected pair at the rising edge. ptr_addr then shows the old value.
- R7: ptr_op 2'b10 (post-increment) makes ptr_addr show the old pointer value and stores old+1 modulo 65536. The carry passes into the high byte.
- R8: ptr_op 2'b11 (pre-decrement) makes ptr_addr show old-1 modulo 65536 and stores that same value. The borrow passes into the high byte.
- R9: When ptr_sel is 2'b11, no op changes any register through the pointer path, and ptr_addr is 0x0000.
- R10: When the 8-bit write and a pointer update target the same register in one cycle, that register takes the pointer byte. An 8-bit write to any register outside the updated pair still takes effect.
- R11: ptr_op 2'b00 (hold) changes no pointer, and ptr_addr shows the current pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | 8 | Read port A data |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | 8-bit write enable |
| wr_addr | input | 5 | 8-bit write register number |
| wr_data | input | 8 | 8-bit write data |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_op | input | 2 | Pointer op: 0 hold, 1 load, 2 post-increment, 3 pre-decrement |
| ptr_ld_data | input | 16 | Value for a pointer load |
| ptr_rd_data | output | 16 | Current value of the selected pointer |
| ptr_addr | output | 16 | Effective address of the pointer access |

## Verification
A bad stored byte shows on a read port on the first cycle after the faulty edge. It also appears on ptr_rd_data when the byte belongs to a pointer pair. A wrong step, a lost carry or borrow, or an inverted priority shows up one cycle later as a pointer value that differs from the arithmetic expectation. The sweeps read every entry through both ports and through the pointer path, so a fault cannot stay hidden for longer than the next read sweep.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD     = 2'b00,
    PTR_LOAD     = 2'b01,
    PTR_POST_INC = 2'b10,
    PTR_PRE_DEC  = 2'b11
  } ptr_op_e;

  localparam logic [1:0] SEL_X    = 2'b00;
  localparam logic [1:0] SEL_Y    = 2'b01;
  localparam logic [1:0] SEL_Z    = 2'b10;
  localparam logic [1:0] SEL_NONE = 2'b11;

endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 5
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [ADDR_W-1:0]               addr,
  output logic [DATA_W-1:0]               data
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0] idx;
  logic             unused_msb;

  // R2: the top address bit is fixed by the numbering and selects nothing
  assign idx        = addr[IDX_W-1:0];
  assign unused_msb = addr[ADDR_W-1];
  assign data       = regs[idx];
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [$clog2(NUM_REGS)-1:0]     wr_idx,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [NUM_REGS-1:0]             ptr_touch,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] ptr_byte,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0] wr_hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    assign wr_hit[i] = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)               regs[i] <= '0;
      else if (ptr_touch[i]) regs[i] <= ptr_byte[i];   // R10 pointer wins
      else if (wr_hit[i])    regs[i] <= wr_data;
    end

    // R10: a collision resolves to the pointer byte
    p_ptr_over_wr_r10: assert property (@(posedge clk) disable iff (rst)
      (wr_hit[i] && ptr_touch[i]) |=> (regs[i] == $past(ptr_byte[i])));

    // R3: an entry not addressed keeps its contents
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!wr_hit[i] && !ptr_touch[i]) |=> $stable(regs[i]));
  end

  // R3: an uncontested write lands in the addressed entry
  p_wr_commit_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_touch[wr_idx]) |=> (regs[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit
  import gpr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_PTRS = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_PTRS-1:0][2*DATA_W-1:0]     ptr_vals,
  input  logic [$clog2(NUM_PTRS+1)-1:0]         sel,
  input  ptr_op_e                               op,
  input  logic [2*DATA_W-1:0]                   ld_data,
  output logic [2*DATA_W-1:0]                   cur_val,
  output logic [2*DATA_W-1:0]                   eff_addr,
  output logic [2*DATA_W-1:0]                   nxt_val,
  output logic [NUM_PTRS-1:0]                   ptr_upd
);
  localparam int PW    = 2 * DATA_W;
  localparam int SEL_W = $clog2(NUM_PTRS + 1);

  // value stored after the access
  function automatic logic [PW-1:0] f_step(input logic [PW-1:0] v,
                                           input ptr_op_e o,
                                           input logic [PW-1:0] ld);
    case (o)
      PTR_LOAD:     return ld;
      PTR_POST_INC: return v + PW'(1);
      PTR_PRE_DEC:  return v - PW'(1);
      default:      return v;
    endcase
  endfunction

  // address presented by the access
  function automatic logic [PW-1:0] f_addr(input logic [PW-1:0] v,
                                           input ptr_op_e o);
    return (o == PTR_PRE_DEC) ? v - PW'(1) : v;
  endfunction

  logic sel_valid;

  always_comb begin
    cur_val   = '0;
    sel_valid = 1'b0;
    for (int p = 0; p < NUM_PTRS; p++) begin
      if (sel == SEL_W'(p)) begin
        cur_val   = ptr_vals[p];
        sel_valid = 1'b1;
      end
    end
  end

  assign nxt_val  = f_step(cur_val, op, ld_data);
  assign eff_addr = sel_valid ? f_addr(cur_val, op) : '0;

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_upd
    assign ptr_upd[p] = sel_valid && (sel == SEL_W'(p)) && (op != PTR_HOLD);

    // R6 R7 R8: the selected pair holds the computed value one edge later
    p_ptr_commit_r6: assert property (@(posedge clk) disable iff (rst)
      ptr_upd[p] |=> (ptr_vals[p] == $past(nxt_val)));

    // R7: stored value is the presented address plus one
    p_post_inc_r7: assert property (@(posedge clk) disable iff (rst)
      (op == PTR_POST_INC && sel == SEL_W'(p))
        |=> (ptr_vals[p] == PW'($past(eff_addr) + PW'(1))));

    // R8: stored value equals the presented address
    p_pre_dec_r8: assert property (@(posedge clk) disable iff (rst)
      (op == PTR_PRE_DEC && sel == SEL_W'(p))
        |=> (ptr_vals[p] == $past(eff_addr)));
  end

  // R9: the reserved select never updates a pair
  p_rsvd_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_W'(SEL_NONE)) |-> (ptr_upd == '0));
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int NUM_PTRS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    rd_a_addr,
  output logic [7:0]    rd_a_data,
  input  logic [4:0]    rd_b_addr,
  output logic [7:0]    rd_b_data,
  input  logic          wr_en,
  input  logic [4:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [1:0]    ptr_sel,
  input  logic [1:0]    ptr_op,
  input  logic [15:0]   ptr_ld_data,
  output logic [15:0]   ptr_rd_data,
  output logic [15:0]   ptr_addr
);
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int ADDR_W    = IDX_W + 1;
  localparam int PW        = 2 * DATA_W;
  localparam int PTR_FIRST = NUM_REGS - 2 * NUM_PTRS;
  localparam int NUM_RD    = 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_REGS-1:0]             ptr_touch;
  logic [NUM_REGS-1:0][DATA_W-1:0] ptr_byte;
  logic [NUM_PTRS-1:0][PW-1:0]     ptr_vals;
  logic [NUM_PTRS-1:0]             ptr_upd;
  logic [PW-1:0]                   ptr_nxt;
  logic [IDX_W-1:0]                wr_idx;
  logic                            unused_wr_msb;
  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;

  assign wr_idx        = wr_addr[IDX_W-1:0];
  assign unused_wr_msb = wr_addr[ADDR_W-1];

  gpr_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .ptr_touch (ptr_touch),
    .ptr_byte  (ptr_byte),
    .regs      (regs)
  );

  // pair p: low byte at the even entry, high byte at the odd one above it
  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_pair
    assign ptr_vals[p] = {regs[PTR_FIRST + 2*p + 1], regs[PTR_FIRST + 2*p]};
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_map
    if (i >= PTR_FIRST) begin : g_ptr
      localparam int P = (i - PTR_FIRST) / 2;
      localparam int B = (i - PTR_FIRST) % 2;
      assign ptr_touch[i] = ptr_upd[P];
      assign ptr_byte[i]  = ptr_nxt[B*DATA_W +: DATA_W];
    end else begin : g_plain
      assign ptr_touch[i] = 1'b0;
      assign ptr_byte[i]  = '0;
    end
  end

  gpr_ptr_unit #(.DATA_W(DATA_W), .NUM_PTRS(NUM_PTRS)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .ptr_vals (ptr_vals),
    .sel      (ptr_sel),
    .op       (ptr_op_e'(ptr_op)),
    .ld_data  (ptr_ld_data),
    .cur_val  (ptr_rd_data),
    .eff_addr (ptr_addr),
    .nxt_val  (ptr_nxt),
    .ptr_upd  (ptr_upd)
  );

  assign rd_addr_v[0] = rd_a_addr;
  assign rd_addr_v[1] = rd_b_addr;

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    gpr_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rd (
      .regs (regs),
      .addr (rd_addr_v[r]),
      .data (rd_data_v[r])
    );
  end

  assign rd_a_data = rd_data_v[0];
  assign rd_b_data = rd_data_v[1];

  // R11: a hold op leaves every pair unchanged unless the 8-bit port writes into one
  p_hold_keeps_r11: assert property (@(posedge clk) disable iff (rst)
    (ptr_op == 2'b00 && !(wr_en && wr_idx >= IDX_W'(PTR_FIRST))) |=> $stable(ptr_vals));

  // R4: a read port observes the previous edge's write only after that edge
  p_read_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_touch[wr_idx]) |=> (regs[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: tb/gpr_bank_tb.sv
module gpr_bank_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [7:0]  rd_a_data, rd_b_data, wr_data;
  logic        wr_en;
  logic [1:0]  ptr_sel, ptr_op;
  logic [15:0] ptr_ld_data, ptr_rd_data, ptr_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int m [16];

  always #5 clk = ~clk;

  gpr_bank u_dut (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_sel(ptr_sel), .ptr_op(ptr_op), .ptr_ld_data(ptr_ld_data),
    .ptr_rd_data(ptr_rd_data), .ptr_addr(ptr_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pval(input int sel);
    if (sel == 3) return 0;
    return m[11 + 2*sel] * 256 + m[10 + 2*sel];
  endfunction

  // one cycle: drive at the falling edge, check combinational outputs, update model after the rising edge
  task automatic step(input string tag, input bit we, input int wa, input int wd,
                      input int ps, input int po, input int pd, input int ra, input int rb);
    int v, ea, nv;
    wr_en = we; wr_addr = 5'(wa); wr_data = 8'(wd);
    ptr_sel = 2'(ps); ptr_op = 2'(po); ptr_ld_data = 16'(pd);
    rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
    #1;
    chk(tag, rd_a_data, m[ra % 16]);
    chk(tag, rd_b_data, m[rb % 16]);
    v  = pval(ps);
    ea = (ps == 3) ? 0 : ((po == 3) ? (v + 65535) % 65536 : v);
    chk({tag, " ptr_rd R5"}, ptr_rd_data, v);
    chk({tag, " ptr_addr"}, ptr_addr, ea);
    @(posedge clk);
    if (we) m[wa % 16] = wd % 256;
    if (ps != 3 && po != 0) begin
      nv = (po == 1) ? pd : ((po == 2) ? (v + 1) % 65536 : (v + 65535) % 65536);
      m[10 + 2*ps] = nv % 256;
      m[11 + 2*ps] = nv / 256;
    end
    @(negedge clk);
  endtask

  task automatic idle_read(input string tag, input int ra, input int rb, input int ps);
    step(tag, 1'b0, 16, 0, ps, 0, 0, ra, rb);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; ptr_sel = 2'd3; ptr_op = '0;
    ptr_ld_data = '0; rd_a_addr = '0; rd_b_addr = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) m[i] = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: all entries read zero after reset
    for (int i = 0; i < 16; i++) idle_read("R1 reset", 16 + i, i, i % 4);

    // R4: same-cycle read sees the old value; R2 via bit-4-clear alias
    for (int i = 0; i < 16; i++)
      step("R4 old on write", 1'b1, 16 + i, (i * 37 + 11) % 256, 3, 0, 0, 16 + i, i);
    for (int i = 0; i < 16; i++) begin
      idle_read("R2 alias", i, 16 + i, 3);
      chk("R2 literal", rd_a_data, (i * 37 + 11) % 256);
    end

    // R3: every pair of read addresses while writing a third entry
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        step("R3 dual read", 1'b1, 16 + (a + b + 1) % 16, a * 16 + b, 3, 0, 0, 16 + a, 16 + b);

    // R5 R6: load each pointer, check bytes through the 8-bit ports
    for (int p = 0; p < 3; p++) begin
      step("R6 load", 1'b0, 16, 0, p, 1, 16'h1234 + p * 16'h1111, 26 + 2*p, 27 + 2*p);
      idle_read("R5 bytes", 26 + 2*p, 27 + 2*p, p);
      chk("R5 low byte", rd_a_data, (16'h1234 + p * 16'h1111) % 256);
      chk("R5 high byte", rd_b_data, (16'h1234 + p * 16'h1111) / 256);
    end

    // R7: post-increment sweeps with carry and wrap
    for (int p = 0; p < 3; p++) begin
      step("R7 setup", 1'b0, 16, 0, p, 1, 16'h00FE, 26, 27);
      for (int k = 0; k < 4; k++) step("R7 post inc", 1'b0, 16, 0, p, 2, 0, 26 + 2*p, 27 + 2*p);
      chk("R7 carry", pval(p), 16'h0102);
      step("R7 setup", 1'b0, 16, 0, p, 1, 16'hFFFF, 26, 27);
      step("R7 wrap", 1'b0, 16, 0, p, 2, 0, 26 + 2*p, 27 + 2*p);
      #1; chk("R7 wrap to zero", ptr_rd_data, 0);
    end

    // R8: pre-decrement sweeps with borrow and wrap
    for (int p = 0; p < 3; p++) begin
      step("R8 setup", 1'b0, 16, 0, p, 1, 16'h0102, 26, 27);
      for (int k = 0; k < 4; k++) step("R8 pre dec", 1'b0, 16, 0, p, 3, 0, 26 + 2*p, 27 + 2*p);
      chk("R8 borrow", pval(p), 16'h00FE);
      step("R8 setup", 1'b0, 16, 0, p, 1, 16'h0000, 26, 27);
      step("R8 wrap", 1'b0, 16, 0, p, 3, 0, 26 + 2*p, 27 + 2*p);
      #1; chk("R8 wrap to ffff", ptr_rd_data, 16'hFFFF);
    end

    // R9: reserved select, every op, pointer bytes observed on the read ports
    for (int o = 0; o < 4; o++)
      for (int r = 0; r < 6; r++)
        step("R9 reserved", 1'b0, 16, 0, 3, o, 16'hBEEF, 26 + r, 26 + (r + 1) % 6);

    // R11: hold op, address is the current value
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 3; k++) step("R11 hold", 1'b0, 16, 0, p, 0, 16'hAAAA, 26 + 2*p, 27 + 2*p);

    // R10: collisions between 8-bit write and pointer update
    step("R10 setup", 1'b0, 16, 0, 0, 1, 16'h00FF, 16, 16);
    step("R10 clash lo", 1'b1, 26, 16'h77, 0, 2, 0, 26, 27);
    idle_read("R10 readback", 26, 27, 0);
    chk("R10 pointer wins", ptr_rd_data, 16'h0100);
    step("R10 setup", 1'b0, 16, 0, 1, 1, 16'h2000, 16, 16);
    step("R10 other pair", 1'b1, 27, 16'h99, 1, 3, 0, 28, 29);
    idle_read("R10 readback", 27, 29, 1);
    chk("R10 other write lands", rd_a_data, 16'h99);
    chk("R10 Y dec", ptr_rd_data, 16'h1FFF);
    step("R10 clash hi", 1'b1, 31, 16'h55, 2, 1, 16'hC3A5, 30, 31);
    idle_read("R10 readback", 30, 31, 2);
    chk("R10 load wins", rd_b_data, 16'hC3);

    // R1: reset after activity clears everything
    do_reset();
    for (int i = 0; i < 16; i++) idle_read("R1 reset again", 16 + i, 31 - i, i % 4);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule